// File: doc/BRIEF.md
# Iterative AES Round Engine

This block encrypts or decrypts a single 128-bit block with AES. It runs one full round per clock cycle and reads round keys from a schedule held outside the block. Key expansion is therefore not part of the engine. A neighbouring key store answers the engine's round-key index in the same cycle. Chaining modes and bus adaptation are left to the surrounding logic.

An operation starts with a one-cycle start pulse while the engine is idle. At that edge the engine captures three inputs: the data block, the direction and the 2-bit key-size code. It then runs 10, 12 or 14 rounds. The `done` level stays low while the engine works. When `done` rises again, the result is on `blk_out`, and it stays there until the next operation completes.

Top module: `aes_iter_core`

## Requirements
- R1: While `rst_n` is low, `done` is 1 and `blk_out` is all zeros.
- R2: A start pulse sampled while `done` is 1 launches an operation, and `done` is 0 in the following cycle.
- R3: `done` stays low for exactly 10, 12 or 14 cycles for `key_len` codes 00, 01 and 10. Code 11 is run as 14 rounds.
- R4: With `encrypt`=1 the result is the AES ciphertext. Byte 0 of each block and each round key sits in bits 127:120. The bench uses the three standard examples with plaintext 00112233445566778899aabbccddeeff. Key 000102...0f (128-bit) gives 69c4e0d86a7b0430d8cdb78070b4c55a. Key 000102...17 (192-bit) gives dda97ca4864cdfe06eaf70a0ec0d7191. Key 000102...1f (256-bit) gives 8ea2b7ca516745bfeafc49904b496089.
- R5: With `encrypt`=0 the result is the AES plaintext, so decrypting any ciphertext returns the original block.
- R6: `rk_idx` is combinational, and `rk_in` must carry round key `rk_idx` in the same cycle. While idle, `rk_idx` is 0 for encryption, or the round count for decryption, taken from the live `encrypt` and `key_len` inputs. During a run it moves by exactly one per cycle, upward for encryption and downward for decryption.
- R7: A start pulse while `done` is 0 is ignored, including in the last round's cycle. The pending operation keeps its latency and result.
- R8: `blk_out` changes only in the cycle in which `done` rises, and it holds its value at all other times.
- R9: Changes to `blk_in`, `encrypt` or `key_len` during a run have no effect on that run's result or latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle launch pulse |
| encrypt | input | 1 | 1 = encrypt, 0 = decrypt; sampled with start |
| key_len | input | 2 | Key size code: 00=128, 01=192, 10=256 (11 as 256) |
| blk_in | input | 128 | Input block, sampled with start |
| rk_idx | output | 4 | Index of the round key wanted this cycle |
| rk_in | input | 128 | Round key selected by rk_idx |
| blk_out | output | 128 | Result block |
| done | output | 1 | High when idle, low while an operation runs |

## Verification
A start pulse can coincide with the cycle that completes the last round. The engine must ignore it there, and must accept a start in the very next cycle. The bench holds start high across both edges, with the first asserted one clock before the last round completes. The second request changes direction and data. The scoreboard expects two separate results, each with the full round latency, and the first result must not be disturbed by the overlapping pulse.

// File: rtl/aes_pkg.sv
package aes_pkg;

   typedef logic [127:0] blk_t;

   function automatic logic [7:0] xt(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] r;
      logic [7:0] p;
      r = 8'h00;
      p = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) r = r ^ p;
         p = xt(p);
      end
      return r;
   endfunction

   // x^254 is the multiplicative inverse in GF(2^8); zero maps to zero
   function automatic logic [7:0] ginv(input logic [7:0] x);
      logic [7:0] p;
      logic [7:0] r;
      p = x;
      r = 8'h01;
      for (int i = 1; i < 8; i++) begin
         p = gmul(p, p);
         r = gmul(r, p);
      end
      return r;
   endfunction

   function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
      return (b << n) | (b >> (8 - n));
   endfunction

   function automatic logic [7:0] sbox(input logic [7:0] x);
      logic [7:0] y;
      y = ginv(x);
      return y ^ rotl8(y, 1) ^ rotl8(y, 2) ^ rotl8(y, 3) ^ rotl8(y, 4) ^ 8'h63;
   endfunction

   function automatic logic [7:0] inv_sbox(input logic [7:0] x);
      logic [7:0] y;
      y = rotl8(x, 1) ^ rotl8(x, 3) ^ rotl8(x, 6) ^ 8'h05;
      return ginv(y);
   endfunction

   // byte i sits at bits [127-8i -: 8]; row = i%4, column = i/4
   function automatic blk_t shift_rows(input blk_t s, input logic inv);
      blk_t o;
      int   src;
      o = '0;
      for (int c = 0; c < 4; c++) begin
         for (int r = 0; r < 4; r++) begin
            src = inv ? ((c - r + 4) % 4) : ((c + r) % 4);
            o[127 - 8 * (r + 4 * c) -: 8] = s[127 - 8 * (r + 4 * src) -: 8];
         end
      end
      return o;
   endfunction

   function automatic logic [3:0] rounds_for(input logic [1:0] code);
      case (code)
         2'b00:   return 4'd10;
         2'b01:   return 4'd12;
         default: return 4'd14;
      endcase
   endfunction

endpackage

// File: rtl/aes_sub_layer.sv
module aes_sub_layer #(
   parameter bit INVERSE = 1'b0
) (
   input  logic [127:0] din,
   output logic [127:0] dout
);
   import aes_pkg::*;

   for (genvar g = 0; g < 16; g++) begin : g_byte
      if (INVERSE) begin : g_inv
         assign dout[8*g +: 8] = inv_sbox(din[8*g +: 8]);
      end else begin : g_fwd
         assign dout[8*g +: 8] = sbox(din[8*g +: 8]);
      end
   end

endmodule

// File: rtl/aes_col_mix.sv
module aes_col_mix #(
   parameter bit INVERSE = 1'b0
) (
   input  logic [31:0] col,
   output logic [31:0] mixed
);
   import aes_pkg::*;

   logic [7:0] a [4];
   logic [7:0] m [4];

   always_comb begin
      for (int r = 0; r < 4; r++) a[r] = col[31 - 8*r -: 8];
      for (int r = 0; r < 4; r++) begin
         if (INVERSE)
            m[r] = gmul(a[r], 8'h0e) ^ gmul(a[(r+1)%4], 8'h0b)
                 ^ gmul(a[(r+2)%4], 8'h0d) ^ gmul(a[(r+3)%4], 8'h09);
         else
            m[r] = xt(a[r]) ^ xt(a[(r+1)%4]) ^ a[(r+1)%4]
                 ^ a[(r+2)%4] ^ a[(r+3)%4];
      end
      for (int r = 0; r < 4; r++) mixed[31 - 8*r -: 8] = m[r];
   end

endmodule

// File: rtl/aes_enc_round.sv
module aes_enc_round (
   input  logic [127:0] st,
   input  logic [127:0] rk,
   input  logic         last,
   output logic [127:0] nxt
);
   import aes_pkg::*;

   logic [127:0] sub, sh, mx;

   aes_sub_layer #(.INVERSE(1'b0)) u_sub (.din(st), .dout(sub));

   assign sh = shift_rows(sub, 1'b0);

   for (genvar c = 0; c < 4; c++) begin : g_col
      aes_col_mix #(.INVERSE(1'b0)) u_mix (
         .col  (sh[127 - 32*c -: 32]),
         .mixed(mx[127 - 32*c -: 32])
      );
   end

   assign nxt = (last ? sh : mx) ^ rk;

endmodule

// File: rtl/aes_dec_round.sv
module aes_dec_round (
   input  logic [127:0] st,
   input  logic [127:0] rk,
   input  logic         last,
   output logic [127:0] nxt
);
   import aes_pkg::*;

   logic [127:0] sh, sub, ak, im;

   assign sh = shift_rows(st, 1'b1);

   aes_sub_layer #(.INVERSE(1'b1)) u_isub (.din(sh), .dout(sub));

   assign ak = sub ^ rk;

   for (genvar c = 0; c < 4; c++) begin : g_col
      aes_col_mix #(.INVERSE(1'b1)) u_imix (
         .col  (ak[127 - 32*c -: 32]),
         .mixed(im[127 - 32*c -: 32])
      );
   end

   assign nxt = last ? ak : im;

endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core #(
   parameter int BLK_W = 128,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             encrypt,
   input  logic [1:0]       key_len,
   input  logic [BLK_W-1:0] blk_in,
   output logic [IDX_W-1:0] rk_idx,
   input  logic [BLK_W-1:0] rk_in,
   output logic [BLK_W-1:0] blk_out,
   output logic             done
);
   import aes_pkg::*;

   if (BLK_W != 128) begin : g_bad_blk
      $error("aes_iter_core: BLK_W must be 128");
   end
   if (IDX_W < 4) begin : g_bad_idx
      $error("aes_iter_core: IDX_W must hold round index 14");
   end

   logic             busy;
   logic             dir_q;
   logic [IDX_W-1:0] nr_q;
   logic [IDX_W-1:0] cnt;
   logic [BLK_W-1:0] st_q;
   logic [BLK_W-1:0] enc_out, dec_out, rnd_out;
   logic             last;

   assign last = (cnt == nr_q);

   aes_enc_round u_enc (.st(st_q), .rk(rk_in), .last(last), .nxt(enc_out));
   aes_dec_round u_dec (.st(st_q), .rk(rk_in), .last(last), .nxt(dec_out));

   assign rnd_out = dir_q ? enc_out : dec_out;
   assign done    = ~busy;

   always_comb begin
      if (busy)
         rk_idx = dir_q ? cnt : (nr_q - cnt);
      else
         rk_idx = encrypt ? '0 : IDX_W'(rounds_for(key_len));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         dir_q   <= 1'b1;
         nr_q    <= '0;
         cnt     <= '0;
         st_q    <= '0;
         blk_out <= '0;
      end else if (!busy) begin
         if (start) begin
            busy  <= 1'b1;
            dir_q <= encrypt;
            nr_q  <= IDX_W'(rounds_for(key_len));
            cnt   <= IDX_W'(1);
            st_q  <= blk_in ^ rk_in;
         end
      end else if (last) begin
         blk_out <= rnd_out;
         busy    <= 1'b0;
      end else begin
         st_q <= rnd_out;
         cnt  <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/aes_iter_core_chk.sv
module aes_iter_core_chk #(
   parameter int BLK_W = 128,
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [1:0]       key_len,
   input logic [IDX_W-1:0] rk_idx,
   input logic [BLK_W-1:0] blk_out,
   input logic             done
);
   logic [4:0] run_cnt;
   logic [4:0] exp_nr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         exp_nr  <= '0;
      end else if (done && start) begin
         run_cnt <= '0;
         exp_nr  <= (key_len == 2'b00) ? 5'd10 : (key_len == 2'b01) ? 5'd12 : 5'd14;
      end else if (!done) begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   // R2
   launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && start |=> !done);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);

   // R3
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> run_cnt == exp_nr);

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(done) |-> $stable(blk_out));

   // R6
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done && $past(!done) |->
         (rk_idx == IDX_W'($past(rk_idx) + 1'b1)) || (rk_idx == IDX_W'($past(rk_idx) - 1'b1)));

   // R6
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> rk_idx <= IDX_W'(14));

endmodule

bind aes_iter_core aes_iter_core_chk #(.BLK_W(BLK_W), .IDX_W(IDX_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .key_len(key_len),
   .rk_idx (rk_idx),
   .blk_out(blk_out),
   .done   (done)
);

// File: tb/aes_iter_core_bench.sv
module aes_iter_core_bench;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         start;
   logic         encrypt;
   logic [1:0]   key_len;
   logic [127:0] blk_in;
   logic [3:0]   rk_idx;
   logic [127:0] rk_in;
   logic [127:0] blk_out;
   logic         done;

   always #4 clk = ~clk;

   aes_iter_core u_aes_iter_core (
      .clk(clk), .rst_n(rst_n), .start(start), .encrypt(encrypt),
      .key_len(key_len), .blk_in(blk_in), .rk_idx(rk_idx), .rk_in(rk_in),
      .blk_out(blk_out), .done(done)
   );

   logic [127:0] rk_mem [0:15];
   assign rk_in = rk_mem[rk_idx];

   localparam logic [127:0] PT     = 128'h00112233445566778899aabbccddeeff;
   localparam logic [255:0] KEY128 = {128'h000102030405060708090a0b0c0d0e0f, 128'h0};
   localparam logic [255:0] KEY192 = {192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'h0};
   localparam logic [255:0] KEY256 = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
   localparam logic [127:0] CT128  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
   localparam logic [127:0] CT192  = 128'hdda97ca4864cdfe06eaf70a0ec0d7191;
   localparam logic [127:0] CT256  = 128'h8ea2b7ca516745bfeafc49904b496089;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [127:0] exp;
      int           rounds;
      bit           chk;
      string        tag;
   } item_t;
   item_t q[$];

   logic [127:0] last_out;
   int           low_cnt = 0;
   bit           prev_done = 1'b1;

   task automatic check(input bit ok, input string tag, input logic [127:0] act,
                        input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference arithmetic, written independently
   function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] p;
      p = '0;
      for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
      for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
      return p[7:0];
   endfunction

   function automatic logic [7:0] bsbox(input logic [7:0] x);
      logic [7:0] v, s;
      logic [7:0] c;
      v = 8'h00;
      c = 8'h63;
      if (x != 0)
         for (int y = 1; y < 256; y++) if (bmul(x, 8'(y)) == 8'h01) v = 8'(y);
      for (int i = 0; i < 8; i++)
         s[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ c[i];
      return s;
   endfunction

   function automatic logic [31:0] subw(input logic [31:0] w);
      return {bsbox(w[31:24]), bsbox(w[23:16]), bsbox(w[15:8]), bsbox(w[7:0])};
   endfunction

   task automatic expand(input logic [255:0] key, input logic [1:0] kl);
      logic [31:0] w [0:59];
      logic [31:0] t;
      logic [7:0]  rcon;
      int nk, nr;
      nk = (kl == 2'b00) ? 4 : (kl == 2'b01) ? 6 : 8;
      nr = nk + 6;
      rcon = 8'h01;
      for (int i = 0; i < nk; i++) w[i] = key[255 - 32*i -: 32];
      for (int i = nk; i < 4*(nr+1); i++) begin
         t = w[i-1];
         if (i % nk == 0) begin
            t = subw({t[23:0], t[31:24]}) ^ {rcon, 24'h0};
            rcon = bmul(rcon, 8'h02);
         end else if (nk > 6 && i % nk == 4) begin
            t = subw(t);
         end
         w[i] = w[i-nk] ^ t;
      end
      for (int r = 0; r < 16; r++)
         rk_mem[r] = (r <= nr) ? {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]} : '0;
   endtask

   task automatic launch(input logic [127:0] din, input bit enc, input logic [1:0] kl,
                         input logic [127:0] exp, input int rounds, input bit chk,
                         input string tag);
      @(negedge clk);
      blk_in  = din;
      encrypt = enc;
      key_len = kl;
      q.push_back('{exp, rounds, chk, tag});
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R2: engine busy one cycle after the pulse
      check(done == 1'b0, "R2 done after start", {127'b0, done}, 128'h0);
   endtask

   task automatic wait_idle();
      while (!done) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         if (!done) low_cnt++;
         else if (!prev_done) begin
            last_out = blk_out;
            if (q.size() == 0) begin
               check(1'b0, "R2 unexpected result", blk_out, 128'h0);
            end else begin
               item_t it;
               it = q.pop_front();
               if (it.chk) check(blk_out == it.exp, it.tag, blk_out, it.exp);
               // R3: busy window length
               check(low_cnt == it.rounds, "R3 latency", 128'(low_cnt), 128'(it.rounds));
            end
            low_cnt = 0;
         end
         prev_done = done;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [127:0] rt_ct;
      rst_n = 1'b0; start = 1'b0; encrypt = 1'b1; key_len = 2'b00; blk_in = '0;
      expand(KEY128, 2'b00);
      repeat (3) @(negedge clk);
      // R1
      check(done == 1'b1 && blk_out == '0, "R1 reset state", blk_out, 128'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: idle index follows live inputs
      encrypt = 1'b1; key_len = 2'b00; #1;
      check(rk_idx == 4'd0, "R6 idle enc index", 128'(rk_idx), 128'd0);
      encrypt = 1'b0; key_len = 2'b01; #1;
      check(rk_idx == 4'd12, "R6 idle dec index", 128'(rk_idx), 128'd12);

      // R4 / R5 with each key size
      launch(PT, 1'b1, 2'b00, CT128, 10, 1'b1, "R4 enc128"); wait_idle();
      launch(CT128, 1'b0, 2'b00, PT, 10, 1'b1, "R5 dec128"); wait_idle();
      expand(KEY192, 2'b01);
      launch(PT, 1'b1, 2'b01, CT192, 12, 1'b1, "R4 enc192"); wait_idle();
      launch(CT192, 1'b0, 2'b01, PT, 12, 1'b1, "R5 dec192"); wait_idle();
      expand(KEY256, 2'b10);
      launch(PT, 1'b1, 2'b10, CT256, 14, 1'b1, "R4 enc256"); wait_idle();
      launch(CT256, 1'b0, 2'b10, PT, 14, 1'b1, "R5 dec256"); wait_idle();
      // R3: code 11 runs as 256-bit
      launch(PT, 1'b1, 2'b11, CT256, 14, 1'b1, "R3 code11 enc"); wait_idle();

      // R8: output holds while idle inputs move
      @(negedge clk);
      blk_in = '1; encrypt = 1'b0; key_len = 2'b01;
      repeat (5) @(negedge clk);
      check(blk_out == CT256, "R8 hold while idle", blk_out, CT256);

      // R9 and R7: inputs and a stray start mid-run
      expand(KEY128, 2'b00);
      launch(PT, 1'b1, 2'b00, CT128, 10, 1'b1, "R9 R7 midrun");
      repeat (2) @(negedge clk);
      blk_in = '0; encrypt = 1'b0; key_len = 2'b10; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(blk_out == CT256, "R8 hold while busy", blk_out, CT256);
      wait_idle();

      // R7: start in last round ignored, next cycle accepted
      launch(PT, 1'b1, 2'b00, CT128, 10, 1'b1, "R7 last-round overlap first");
      repeat (9) @(negedge clk);
      blk_in = CT128; encrypt = 1'b0; key_len = 2'b00; start = 1'b1;
      q.push_back('{PT, 10, 1'b1, "R7 last-round overlap second"});
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      wait_idle();

      // R5: round trip on arbitrary data with 256-bit key
      expand(KEY256, 2'b10);
      launch(128'hdeadbeef_0badf00d_13572468_cafebabe, 1'b1, 2'b10, '0, 14, 1'b0, "R4 rt enc");
      wait_idle();
      @(negedge clk);
      rt_ct = last_out;
      launch(rt_ct, 1'b0, 2'b10, 128'hdeadbeef_0badf00d_13572468_cafebabe, 14, 1'b1, "R5 round trip");
      wait_idle();

      repeat (3) @(negedge clk);
      check(q.size() == 0, "R2 results outstanding", 128'(q.size()), 128'd0);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule